// File: doc/BRIEF.md
# Read-Modify-Write Store Adapter

This block connects a 32-bit processor data port to a 32-bit word memory whose only write control is a single strobe for the whole word. The memory has no way to update one byte or one halfword on its own. The adapter makes a narrow store safe in three steps. It reads the addressed word, replaces only the byte lanes that the core's byte enables select, and writes the complete merged word back. While this runs, it holds the core with a halt signal. Loads use the same front half of the sequence: one read of the word, whose data reaches the core unchanged. Read and write traffic therefore present the same access pattern to the memory.

The core raises `cpu_wr` or `cpu_rd` with the word address, store data and byte enables, and keeps them steady until it sees `cpu_halt` low at a clock edge. Addresses are word addresses. The memory is a synchronous RAM: data for a read issued in one cycle appears on `mem_rdata` in the next cycle and stays there until the next read.

Top module: `rmw_store_adapter`

## Requirements
- R1: After reset, with no request present, `cpu_halt`, `mem_rd` and `mem_wr` are all low.
- R2: `cpu_halt` goes high in the same cycle that a store or load request first appears while the adapter is idle.
- R3: In the cycle after a request is accepted, `mem_rd` is high, `mem_wr` is low and `mem_addr` equals the request address.
- R4: For a store, in the cycle after the read, `mem_wr` is high on the same address. Byte lane i is `mem_wdata[8i+7:8i]`. It carries store data lane i when byte enable bit i is 1, and the word read back otherwise.
- R5: A store with all four byte enables set (`4'b1111`) still performs the read and then the write, with the same halt timing as a narrow store.
- R6: A store with no byte enable set (`4'b0000`) writes the word back exactly as it was read.
- R7: `cpu_halt` is low in the cycle after the merged write. It stays high from acceptance up to that cycle, for three cycles in total. After this the adapter is idle again.
- R8: A load performs one read and never raises `mem_wr`. `cpu_halt` is low in the cycle after the read, and `cpu_rdata` then equals the stored word unchanged.
- R9: If `cpu_rd` and `cpu_wr` are both high when a request is accepted, the request is treated as a store.
- R10: In the release cycle, when `cpu_halt` is low, the still-held request starts no memory access: `mem_rd` and `mem_wr` are low.
- R11: `mem_rd` and `mem_wr` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_rd | input | 1 | Load request, held until released |
| cpu_wr | input | 1 | Store request, held until released |
| cpu_addr | input | ADDR_W | Word address of the access |
| cpu_wdata | input | DATA_W | Store data |
| cpu_be | input | DATA_W/8 | Byte enables of the store, bit i selects lane i |
| cpu_halt | output | 1 | Holds the core while the sequence runs |
| cpu_rdata | output | DATA_W | Load data, valid when halt drops after a load |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory whole-word write strobe |
| mem_addr | output | ADDR_W | Memory word address |
| mem_wdata | output | DATA_W | Merged word to be written |
| mem_rdata | input | DATA_W | Memory read data, one cycle after the read strobe |

## Verification
Two functions meet in the write cycle of a store. The memory's read data returns in that cycle, and the merge must turn it into write data before the same clock edge. The bench runs stores with single-byte, halfword, mixed, full and empty enable patterns onto words that earlier stores changed. A scoreboard holds each expected merged word, built from a shadow copy of the memory, and compares it against the write strobe's address and data. A second collision is a request with both load and store asserted in one cycle. The bench judges it by the write that appears and by the later load data.

// File: rtl/rmw_pkg.sv
package rmw_pkg;

    typedef enum logic [1:0] {
        SEQ_IDLE  = 2'd0,
        SEQ_READ  = 2'd1,
        SEQ_WRITE = 2'd2,
        SEQ_DONE  = 2'd3
    } seq_state_e;

endpackage

// File: rtl/rmw_lane_merge.sv
module rmw_lane_merge #(
    parameter int LANES = 4,
    localparam int WIDTH = LANES * 8
) (
    input  logic [WIDTH-1:0] old_word,
    input  logic [WIDTH-1:0] new_word,
    input  logic [LANES-1:0] lane_sel,
    output logic [WIDTH-1:0] merged
);

    // One byte-wide multiplexer per lane
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign merged[g*8 +: 8] = lane_sel[g] ? new_word[g*8 +: 8] : old_word[g*8 +: 8];
    end

endmodule

// File: rtl/rmw_seq.sv
module rmw_seq
    import rmw_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req_rd,
    input  logic req_wr,
    output logic capture,
    output logic halt,
    output logic issue_rd,
    output logic issue_wr
);

    typedef struct packed {
        seq_state_e state;
        logic       store;
    } seq_regs_t;

    seq_regs_t seq_d, seq_q;
    logic      any_req;

    assign any_req = req_rd | req_wr;

    always_comb begin
        seq_d   = seq_q;
        capture = 1'b0;
        unique case (seq_q.state)
            SEQ_IDLE: begin
                if (any_req) begin
                    capture     = 1'b1;
                    seq_d.state = SEQ_READ;
                    seq_d.store = req_wr;   // a store wins over a load
                end
            end
            SEQ_READ:  seq_d.state = seq_q.store ? SEQ_WRITE : SEQ_DONE;
            SEQ_WRITE: seq_d.state = SEQ_DONE;
            SEQ_DONE:  seq_d.state = SEQ_IDLE;  // held request is not restarted
            default:   seq_d.state = SEQ_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seq_q.state <= SEQ_IDLE;
            seq_q.store <= 1'b0;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign halt     = (seq_q.state == SEQ_IDLE) ? any_req : (seq_q.state != SEQ_DONE);
    assign issue_rd = (seq_q.state == SEQ_READ);
    assign issue_wr = (seq_q.state == SEQ_WRITE);

    assert_read_after_accept_R3: assert property (@(posedge clk) disable iff (!rst_n)
        capture |=> (issue_rd && !issue_wr));

    assert_write_after_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_rd && seq_q.store) |=> issue_wr);

    assert_release_after_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
        issue_wr |=> (!halt && !issue_rd && !issue_wr));

    assert_load_no_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_rd && !seq_q.store) |=> (!issue_wr && !halt));

    assert_both_means_store_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (capture && req_rd && req_wr) |=> ##1 issue_wr);

    assert_strobes_exclusive_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !(issue_rd && issue_wr));

endmodule

// File: rtl/rmw_store_adapter.sv
module rmw_store_adapter #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32,
    localparam int LANES = DATA_W / 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_rd,
    input  logic              cpu_wr,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    input  logic [LANES-1:0]  cpu_be,
    output logic              cpu_halt,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata
);

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
        logic [LANES-1:0]  be;
    } req_regs_t;

    req_regs_t req_d, req_q;
    logic      capture;

    rmw_seq i_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .req_rd   (cpu_rd),
        .req_wr   (cpu_wr),
        .capture  (capture),
        .halt     (cpu_halt),
        .issue_rd (mem_rd),
        .issue_wr (mem_wr)
    );

    always_comb begin
        req_d = req_q;
        if (capture) begin
            req_d.addr = cpu_addr;
            req_d.data = cpu_wdata;
            req_d.be   = cpu_be;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_q <= '0;
        end else begin
            req_q <= req_d;
        end
    end

    rmw_lane_merge #(.LANES(LANES)) i_merge (
        .old_word (mem_rdata),
        .new_word (req_q.data),
        .lane_sel (req_q.be),
        .merged   (mem_wdata)
    );

    assign mem_addr  = req_q.addr;
    assign cpu_rdata = mem_rdata;   // load data passes unchanged

    assert_write_same_addr_R4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr |-> (mem_addr == $past(mem_addr) && $past(mem_rd)));

    assert_release_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ((cpu_rd || cpu_wr) && !cpu_halt) |-> (!mem_rd && !mem_wr));

    assert_empty_be_unchanged_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr && req_q.be == '0) |-> (mem_wdata == mem_rdata));

    assert_full_be_new_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr && req_q.be == '1) |-> (mem_wdata == req_q.data));

endmodule

// File: tb/test_rmw_store_adapter.sv
module test_rmw_store_adapter;

    localparam int AW = 16;
    localparam int DW = 32;
    localparam int NB = DW / 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cpu_rd = 1'b0;
    logic          cpu_wr = 1'b0;
    logic [AW-1:0] cpu_addr = '0;
    logic [DW-1:0] cpu_wdata = '0;
    logic [NB-1:0] cpu_be = '0;
    logic          cpu_halt;
    logic [DW-1:0] cpu_rdata;
    logic          mem_rd, mem_wr;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_wdata;
    logic [DW-1:0] mem_rdata = '0;

    logic [DW-1:0] ram    [16];
    logic [DW-1:0] shadow [16];
    logic [AW+DW-1:0] sb_q [$];

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    rmw_store_adapter #(.ADDR_W(AW), .DATA_W(DW)) i_rmw_store_adapter (
        .clk(clk), .rst_n(rst_n), .cpu_rd(cpu_rd), .cpu_wr(cpu_wr),
        .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_be(cpu_be),
        .cpu_halt(cpu_halt), .cpu_rdata(cpu_rdata), .mem_rd(mem_rd),
        .mem_wr(mem_wr), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata)
    );

    // Synchronous word RAM
    always @(posedge clk) begin
        if (mem_wr) ram[mem_addr[3:0]] <= mem_wdata;
        if (mem_rd) mem_rdata <= ram[mem_addr[3:0]];
    end

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Scoreboard monitor: every write strobe is compared with the next expected item
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            check(!(mem_rd && mem_wr), "R11 strobes both high", {mem_rd, mem_wr}, 2'b00);
            if (mem_wr) begin
                if (sb_q.size() == 0) begin
                    check(1'b0, "R4 unexpected write", mem_wdata, 0);
                end else begin
                    logic [AW+DW-1:0] item;
                    item = sb_q.pop_front();
                    check(mem_addr == item[AW+DW-1:DW], "R4 write address", mem_addr, item[AW+DW-1:DW]);
                    check(mem_wdata == item[DW-1:0], "R4 merged word", mem_wdata, item[DW-1:0]);
                end
            end
        end
    end

    task automatic do_store(input logic [AW-1:0] a, input logic [DW-1:0] d,
                            input logic [NB-1:0] be, input bit with_rd, input string tag);
        logic [DW-1:0] old_w, exp_w;
        old_w = shadow[a[3:0]];
        for (int i = 0; i < NB; i++)
            exp_w[i*8 +: 8] = be[i] ? d[i*8 +: 8] : old_w[i*8 +: 8];
        sb_q.push_back({a, exp_w});
        shadow[a[3:0]] = exp_w;
        @(negedge clk);
        cpu_wr = 1'b1; cpu_rd = with_rd; cpu_addr = a; cpu_wdata = d; cpu_be = be;
        #1 check(cpu_halt == 1'b1, {"R2 halt on store ", tag}, cpu_halt, 1);
        @(negedge clk);
        check(mem_rd && !mem_wr && mem_addr == a, {"R3 read issued ", tag}, {mem_rd, mem_wr, mem_addr}, {2'b10, a});
        check(cpu_halt == 1'b1, {"R5 halt in read ", tag}, cpu_halt, 1);
        @(negedge clk);
        check(mem_wr && cpu_halt, {"R4 write cycle ", tag}, {mem_wr, cpu_halt}, 2'b11);
        @(negedge clk);
        check(!cpu_halt, {"R7 release ", tag}, cpu_halt, 0);
        check(!mem_rd && !mem_wr, {"R10 quiet release ", tag}, {mem_rd, mem_wr}, 2'b00);
        @(negedge clk);
        cpu_wr = 1'b0; cpu_rd = 1'b0;
        #1 check(!cpu_halt && !mem_rd && !mem_wr, {"R7 idle again ", tag}, {cpu_halt, mem_rd, mem_wr}, 3'b000);
    endtask

    task automatic do_load(input logic [AW-1:0] a, input string tag);
        @(negedge clk);
        cpu_rd = 1'b1; cpu_addr = a; cpu_wdata = 32'hDEAD_BEEF; cpu_be = 4'b1111;
        #1 check(cpu_halt == 1'b1, {"R2 halt on load ", tag}, cpu_halt, 1);
        @(negedge clk);
        check(mem_rd && !mem_wr && mem_addr == a, {"R3 load read ", tag}, {mem_rd, mem_wr, mem_addr}, {2'b10, a});
        @(negedge clk);
        check(!cpu_halt && !mem_wr, {"R8 load release ", tag}, {cpu_halt, mem_wr}, 2'b00);
        check(cpu_rdata == shadow[a[3:0]], {"R8 load data ", tag}, cpu_rdata, shadow[a[3:0]]);
        @(negedge clk);
        cpu_rd = 1'b0;
    endtask

    task automatic finish_run();
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        for (int i = 0; i < 16; i++) begin
            ram[i] = 32'h1000_0000 * (i % 8) + 32'h0101_0101 * i + 32'h8040_2010;
            shadow[i] = ram[i];
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1 check(!cpu_halt && !mem_rd && !mem_wr, "R1 reset state", {cpu_halt, mem_rd, mem_wr}, 3'b000);

        do_store(16'd2, 32'hAABB_CCDD, 4'b0001, 0, "byte0");
        do_store(16'd2, 32'h1122_3344, 4'b0110, 0, "middle half");
        do_store(16'd2, 32'h5566_7788, 4'b1100, 0, "upper half");
        do_load (16'd2, "after merges");
        do_store(16'd5, 32'hCAFE_F00D, 4'b1111, 0, "R5 full word");
        do_load (16'd5, "full word");
        do_store(16'd7, 32'h0BAD_0BAD, 4'b0000, 0, "R6 no lanes");
        do_load (16'd7, "R6 untouched");
        do_store(16'd9, 32'h99AA_BBCC, 4'b1010, 1, "R9 rd and wr");
        do_load (16'd9, "R9 result");
        do_store(16'd9, 32'h0000_00EE, 4'b0001, 0, "back to back a");
        do_store(16'd9, 32'h00FF_0000, 4'b0100, 0, "back to back b");
        do_load (16'd9, "back to back");
        do_load (16'd0, "untouched word");

        repeat (2) @(negedge clk);
        check(sb_q.size() == 0, "R4 all writes seen", sb_q.size(), 0);
        finish_run();
    end

    initial begin
        #2000000;
        check(1'b0, "watchdog expired", 0, 1);
        finish_run();
    end

endmodule